// File: doc/BRIEF.md
# Staged Platform Reset Sequencer

This block orders the reset release of a memory-controller-style chip. An active-low reset input arrives from the I/O companion chip, and a power-good flag comes from the platform. The sequence starts once the reset input is high and power-good is present. The block first waits for all internal clock domains to reach a common rising edge, and then releases the internal hard and core resets together. It keeps the processor reset asserted for a programmable hold interval. This interval is given in main-clock cycles and stands for about one millisecond.

When the hold interval expires, the block sends a "reset done" request to the companion chip. The processor reset is released only when that request has been acknowledged, so the handshake time adds to the hold interval and is not absorbed by it. After the release, a second "processor reset done" request follows. If the reset input is asserted again, or power-good drops, the block returns at once to its starting state.

Top module: `plat_rst_seq`

## Requirements
- R1: Edge 0 is the first rising clock edge that samples `sys_rst_n`=1 and `pwr_ok`=1, and later edges are counted from it. `hard_rst_n` and `core_rst_n` go to 1 on the first edge k with k ≥ 4 at which `clk_align` is sampled high. If no such pulse arrives, they go to 1 on edge 6. A pulse before edge 4 is ignored.
- R2: `hard_rst_n` and `core_rst_n` change from 0 to 1 on the same clock edge.
- R3: `cpu_rst_n` stays 0 at least through edge `CPU_HOLD`. On edge `CPU_HOLD`, `hs_req_done` goes high for one cycle.
- R4: After `hs_req_done`, `cpu_rst_n` goes to 1 on the first edge that samples `hs_ack`=1. The release therefore comes at edge `CPU_HOLD` plus the acknowledge latency.
- R5: `hs_req_cpu` goes high for one cycle on the edge after `cpu_rst_n` rises. A later sampled `hs_ack` completes the sequence.
- R6: `hs_ack` has no effect while the block is not waiting for an acknowledgement, either during the hold interval or after the sequence is complete. It neither releases `cpu_rst_n` early nor produces extra requests.
- R7: While the first acknowledgement is missing, `cpu_rst_n` stays 0 and `hs_req_cpu` stays 0, however long the wait.
- R8: An edge that samples `sys_rst_n`=0 or `pwr_ok`=0 drives all three reset outputs to 0 (asserted) and both request strobes to 0. It also clears the hold timer, so a new sequence measures its intervals from its own edge 0.
- R9: Each of `hs_req_done` and `hs_req_cpu` is a single-cycle pulse, issued once per sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| sys_rst_n | input | 1 | Active-low reset from the companion chip |
| pwr_ok | input | 1 | Power-good flag, high when power is stable |
| clk_align | input | 1 | Pulse marking a common rising edge of all internal clocks |
| hs_ack | input | 1 | Acknowledgement from the companion chip for the current request |
| hard_rst_n | output | 1 | Internal hard reset, 0 = asserted |
| core_rst_n | output | 1 | Internal core reset, 0 = asserted |
| cpu_rst_n | output | 1 | Processor reset, 0 = asserted |
| hs_req_done | output | 1 | One-cycle "reset done" request strobe |
| hs_req_cpu | output | 1 | One-cycle "processor reset done" request strobe |

## Verification
The main sequence is tried with alignment pulses placed before the window, at each edge inside the window, after the window, and left out altogether. These cases separate a release triggered by the pulse from a release forced by the timeout, and from a pulse that is wrongly accepted too early. Varying the two acknowledge latencies shows whether the processor release moves with the handshake time or stays pinned to the timer. Stray acknowledgements, a stalled acknowledgement, and reset or power-good loss in the middle of a sequence show whether the handshake is properly gated and whether the timer restarts.

// File: rtl/rst_seq_pkg.sv
// Shared types for the staged platform reset sequencer.
package rst_seq_pkg;

    // Handshake phase after the internal resets are released.
    typedef enum logic [2:0] {
        HS_IDLE  = 3'd0,   // hold timer still running
        HS_ACK1  = 3'd1,   // "reset done" sent, awaiting acknowledge
        HS_SEND2 = 3'd2,   // processor reset released, issue second request
        HS_ACK2  = 3'd3,   // "processor reset done" sent, awaiting acknowledge
        HS_DONE  = 3'd4    // sequence complete
    } hs_state_e;

endpackage

// File: rtl/rst_cycle_counter.sv
// Saturating cycle counter.
// Counts clock edges since the sequence start and stops at MAX.
// Assumes: clr is the synchronous restart (sequence held in reset).
module rst_cycle_counter #(
    parameter int MAX = 100000,
    parameter int CW  = $clog2(MAX + 1)
) (
    input  logic          clk,
    input  logic          clr,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] MAX_C = CW'(MAX);

    // Count up from zero, hold at MAX.
    always_ff @(posedge clk) begin
        if (clr)
            cnt <= '0;
        else if (cnt != MAX_C)
            cnt <= cnt + 1'b1;
    end

    // R8: the count advances by one per edge until saturation
    p_cnt_step_r8: assert property (@(posedge clk) disable iff (clr)
        (cnt != MAX_C) |=> (cnt == $past(cnt) + 1'b1));

endmodule

// File: rtl/rst_align_gate.sv
// Clock-alignment release gate.
// Releases the internal resets on the first alignment pulse sampled at or
// after edge MIN_WAIT, or at edge MAX_WAIT if no pulse arrives.
// Assumes: cnt equals the number of edges seen since the sequence start.
module rst_align_gate #(
    parameter int MIN_WAIT = 4,
    parameter int MAX_WAIT = 6,
    parameter int CW       = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [CW-1:0] cnt,
    input  logic          clk_align,
    output logic          released
);
    localparam logic [CW-1:0] MIN_C   = CW'(MIN_WAIT);
    localparam logic [CW-1:0] MAX_C   = CW'(MAX_WAIT);
    localparam logic [CW-1:0] MIN_P1  = CW'(MIN_WAIT + 1);
    localparam logic [CW-1:0] MAX_P1  = CW'(MAX_WAIT + 1);

    logic in_window;
    assign in_window = (cnt >= MIN_C);

    // Latch the release once the window opens and alignment (or timeout) is seen.
    always_ff @(posedge clk) begin
        if (clr)
            released <= 1'b0;
        else if (!released && in_window && (clk_align || cnt >= MAX_C))
            released <= 1'b1;
    end

    // R1: release appears only after edges MIN_WAIT..MAX_WAIT
    p_rel_window_r1: assert property (@(posedge clk) disable iff (clr)
        $rose(released) |-> (cnt >= MIN_P1 && cnt <= MAX_P1));

    // R1: once released the gate stays released within a sequence
    p_rel_sticky_r1: assert property (@(posedge clk) disable iff (clr)
        released |=> released);

endmodule

// File: rtl/rst_hs_fsm.sv
// Processor reset and companion-chip handshake controller.
// After the hold timer expires it sends "reset done", releases the processor
// reset on its acknowledge, then sends "processor reset done".
// Assumes: go is high once internal resets are released and the timer expired.
module rst_hs_fsm
    import rst_seq_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic go,
    input  logic hs_ack,
    output logic cpu_rst_n,
    output logic req_done,
    output logic req_cpu
);
    hs_state_e st;

    // Step through the handshake; strobes default low each cycle.
    always_ff @(posedge clk) begin
        if (clr) begin
            st        <= HS_IDLE;
            cpu_rst_n <= 1'b0;
            req_done  <= 1'b0;
            req_cpu   <= 1'b0;
        end else begin
            req_done <= 1'b0;
            req_cpu  <= 1'b0;
            case (st)
                HS_IDLE: if (go) begin
                    req_done <= 1'b1;
                    st       <= HS_ACK1;
                end
                HS_ACK1: if (hs_ack) begin
                    cpu_rst_n <= 1'b1;
                    st        <= HS_SEND2;
                end
                HS_SEND2: begin
                    req_cpu <= 1'b1;
                    st      <= HS_ACK2;
                end
                HS_ACK2: if (hs_ack) st <= HS_DONE;
                default: ;
            endcase
        end
    end

    // R3: processor reset only leaves reset after the timer expired
    p_cpu_after_timer_r3: assert property (@(posedge clk) disable iff (clr)
        cpu_rst_n |-> go);

    // R4: processor reset rises only on a sampled acknowledge
    p_cpu_on_ack_r4: assert property (@(posedge clk) disable iff (clr)
        $rose(cpu_rst_n) |-> $past(hs_ack));

    // R5: second request follows the processor reset release
    p_req2_order_r5: assert property (@(posedge clk) disable iff (clr)
        req_cpu |-> (cpu_rst_n && $past(cpu_rst_n) && !$past(cpu_rst_n, 2)));

    // R9: request strobes are single-cycle and never overlap
    p_req1_pulse_r9: assert property (@(posedge clk) disable iff (clr)
        req_done |=> !req_done);
    p_req2_pulse_r9: assert property (@(posedge clk) disable iff (clr)
        req_cpu |=> !req_cpu);
    p_req_excl_r9: assert property (@(posedge clk) disable iff (clr)
        $onehot0({req_done, req_cpu}));

endmodule

// File: rtl/plat_rst_seq.sv
// Staged platform reset sequencer (top).
// Restarts whenever the companion reset input or power-good is low, releases
// hard and core resets at a clock-aligned edge, then holds the processor reset
// for CPU_HOLD cycles plus the handshake.
// Assumes: CPU_HOLD > ALIGN_MAX; inputs are synchronous to clk.
module plat_rst_seq #(
    parameter int CPU_HOLD  = 100000,
    parameter int ALIGN_MIN = 4,
    parameter int ALIGN_MAX = 6
) (
    input  logic clk,
    input  logic sys_rst_n,
    input  logic pwr_ok,
    input  logic clk_align,
    input  logic hs_ack,
    output logic hard_rst_n,
    output logic core_rst_n,
    output logic cpu_rst_n,
    output logic hs_req_done,
    output logic hs_req_cpu
);
    localparam int CW = $clog2(CPU_HOLD + 1);
    localparam logic [CW-1:0] HOLD_C = CW'(CPU_HOLD);

    logic          seq_clr;
    logic [CW-1:0] cyc;
    logic          domains_up;
    logic          tmr_hit;

    // Sequence restarts while either upstream condition is missing.
    assign seq_clr = !sys_rst_n || !pwr_ok;

    rst_cycle_counter #(.MAX(CPU_HOLD), .CW(CW)) u_cnt (
        .clk (clk),
        .clr (seq_clr),
        .cnt (cyc)
    );

    rst_align_gate #(.MIN_WAIT(ALIGN_MIN), .MAX_WAIT(ALIGN_MAX), .CW(CW)) u_gate (
        .clk       (clk),
        .clr       (seq_clr),
        .cnt       (cyc),
        .clk_align (clk_align),
        .released  (domains_up)
    );

    // Hold interval reached (counter saturates at CPU_HOLD).
    assign tmr_hit = (cyc == HOLD_C);

    rst_hs_fsm u_hs (
        .clk       (clk),
        .clr       (seq_clr),
        .go        (domains_up && tmr_hit),
        .hs_ack    (hs_ack),
        .cpu_rst_n (cpu_rst_n),
        .req_done  (hs_req_done),
        .req_cpu   (hs_req_cpu)
    );

    // Hard and core resets share the aligned release.
    assign hard_rst_n = domains_up;
    assign core_rst_n = domains_up;

    // R8: a sampled reset or power loss asserts everything on the next cycle
    p_restart_r8: assert property (@(posedge clk)
        seq_clr |=> (!hard_rst_n && !core_rst_n && !cpu_rst_n
                     && !hs_req_done && !hs_req_cpu));

    // R2: processor reset never leaves reset ahead of the internal resets
    p_cpu_after_core_r2: assert property (@(posedge clk) disable iff (seq_clr)
        cpu_rst_n |-> (hard_rst_n && core_rst_n));

endmodule

// File: tb/sim_plat_rst_seq.sv
module sim_plat_rst_seq;
    localparam int HOLD = 40;
    localparam int NV   = 7;
    // align_at, ack1 latency, ack2 latency, expected release edge
    localparam int VEC [NV][4] = '{
        '{5,  1, 1, 5},
        '{2,  3, 2, 6},
        '{4,  2, 1, 4},
        '{99, 1, 4, 6},
        '{6,  5, 1, 6},
        '{7,  1, 1, 6},
        '{3,  4, 3, 6}
    };

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic sys_rst_n = 1'b0, pwr_ok = 1'b0, clk_align = 1'b0, hs_ack = 1'b0;
    logic hard_rst_n, core_rst_n, cpu_rst_n, hs_req_done, hs_req_cpu;
    int n_run = 0, n_fail = 0;
    int e_hard, e_core, e_req1, e_cpu, e_req2, n_req1, n_req2;

    plat_rst_seq #(.CPU_HOLD(HOLD)) u0 (
        .clk(clk), .sys_rst_n(sys_rst_n), .pwr_ok(pwr_ok), .clk_align(clk_align),
        .hs_ack(hs_ack), .hard_rst_n(hard_rst_n), .core_rst_n(core_rst_n),
        .cpu_rst_n(cpu_rst_n), .hs_req_done(hs_req_done), .hs_req_cpu(hs_req_cpu)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Called at a negedge with the sequence held in reset; edge 0 is the next posedge.
    task automatic run_seq(int align_at, int lat1, int lat2, int stray_at, int limit);
        int a1 = -1;
        int a2 = -1;
        e_hard = -1; e_core = -1; e_req1 = -1; e_cpu = -1; e_req2 = -1;
        n_req1 = 0; n_req2 = 0;
        sys_rst_n = 1'b1;
        for (int k = 0; k < limit; k++) begin
            clk_align = (k == align_at);
            hs_ack    = (k == a1) || (k == a2) || (k == stray_at);
            @(posedge clk); @(negedge clk);
            if (hard_rst_n && e_hard < 0) e_hard = k;
            if (core_rst_n && e_core < 0) e_core = k;
            if (cpu_rst_n && e_cpu < 0)   e_cpu = k;
            if (hs_req_done) begin n_req1++; e_req1 = k; a1 = (lat1 > 0) ? k + lat1 : -1; end
            if (hs_req_cpu)  begin n_req2++; e_req2 = k; a2 = k + lat2; end
        end
        clk_align = 1'b0;
        hs_ack    = 1'b0;
    endtask

    task automatic hold_reset(int n);
        sys_rst_n = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    function automatic int outs();
        return int'({hard_rst_n, core_rst_n, cpu_rst_n, hs_req_done, hs_req_cpu});
    endfunction

    initial begin
        #(200000 * 10);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        // Power-on ordering: stable power, then power-good, then reset input released.
        repeat (30) @(negedge clk);
        chk("R8", "outputs before power-good", outs(), 0);
        pwr_ok = 1'b1;
        repeat (20) @(negedge clk);
        chk("R8", "outputs with power-good, reset input low", outs(), 0);

        for (int v = 0; v < NV; v++) begin
            run_seq(VEC[v][0], VEC[v][1], VEC[v][2], -1, HOLD + 20);
            chk("R1", "hard release edge", e_hard, VEC[v][3]);
            chk("R2", "core edge vs hard edge", e_core, e_hard);
            chk("R3", "reset-done request edge", e_req1, HOLD);
            chk("R4", "processor release edge", e_cpu, HOLD + VEC[v][1]);
            chk("R5", "second request edge", e_req2, e_cpu + 1);
            chk("R9", "request pulse counts", n_req1 * 10 + n_req2, 11);
            hold_reset(3);
        end

        // R6: stray acknowledge during the hold interval
        run_seq(5, 2, 1, 12, HOLD + 20);
        chk("R6", "processor release with early stray ack", e_cpu, HOLD + 2);
        chk("R6", "request pulses with early stray ack", n_req1 * 10 + n_req2, 11);
        hold_reset(3);
        // R6: stray acknowledge after completion
        run_seq(5, 2, 1, HOLD + 15, HOLD + 20);
        chk("R6", "request pulses with late stray ack", n_req1 * 10 + n_req2, 11);
        chk("R6", "processor reset after late stray ack", int'(cpu_rst_n), 1);
        hold_reset(3);

        // R7: first acknowledge never arrives
        run_seq(5, 0, 1, -1, HOLD + 200);
        chk("R7", "processor release with stalled ack", e_cpu, -1);
        chk("R7", "second request with stalled ack", n_req2, 0);
        chk("R7", "processor reset at end of stall", int'(cpu_rst_n), 0);
        hold_reset(3);

        // R8: reset input reasserted mid-sequence, then timer restarts
        run_seq(5, 1, 1, -1, 20);
        chk("R8", "internal resets released before abort", int'(hard_rst_n), 1);
        sys_rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8", "outputs one edge after reset reassert", outs(), 0);
        hold_reset(2);
        run_seq(99, 1, 1, -1, HOLD + 20);
        chk("R8", "processor release after restart", e_cpu, HOLD + 1);

        // R8: power-good lost after a complete sequence
        chk("R8", "processor reset released before power loss", int'(cpu_rst_n), 1);
        pwr_ok = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R8", "outputs one edge after power loss", outs(), 0);
        sys_rst_n = 1'b0;
        pwr_ok = 1'b1;
        hold_reset(2);
        run_seq(4, 3, 1, -1, HOLD + 20);
        chk("R1", "release edge after power return", e_hard, 4);
        chk("R4", "processor release after power return", e_cpu, HOLD + 3);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule